// File: doc/BRIEF.md
# Posted Write Buffer with Read Snoop

This block sits between a processor bus and a memory controller. It lets the processor post whole-line writes and move on without waiting for memory. The block holds up to `DEPTH` lines. Each line has its own address tag and valid bit, and the lines retire to memory strictly in arrival order through a single request/acknowledge port. A write is taken as soon as a free slot exists. When every slot is occupied, the write ready is withheld until a slot drains.

Every processor read is compared against the tags of all valid slots. The comparison works at line granularity, so the byte-offset bits are ignored. On a match the read is held off: ready stays low while the queue drains, until no valid slot carries that line any more, and only then does the read reach memory. If no slot matches, the read goes to memory ahead of the queued writes. It wins the port at the next moment the port is idle. The line read from memory is returned on the processor side in the cycle of the memory acknowledge.

Top module: `wbuf_snoop`

## Requirements
- R1: After reset the buffer is empty, `mem_req_o` is low and `cpu_rdy_o` is low while no request is presented.
- R2: A write (`cpu_req_i`=1, `cpu_we_i`=1) is accepted with `cpu_rdy_o` high in the same cycle whenever fewer than `DEPTH` lines are pending.
- R3: With `DEPTH` lines pending, a write sees `cpu_rdy_o` low. It is accepted in the first cycle after the cycle in which a retire is acknowledged.
- R4: Pending lines retire in acceptance order. Each retire presents `mem_we_o`=1, `mem_addr_o` equal to the written address with bits [4:0] forced to zero, and `mem_wdata_o` equal to the accepted 256-bit line.
- R5: A read whose address bits [ADDR_W-1:5] equal the tag of any valid pending line sees `cpu_rdy_o` low. It is not issued to memory until every such line has retired. Address bits [4:0] take no part in the comparison.
- R6: When the memory port is idle and a read misses every valid line, the read is issued next (`mem_we_o`=0) ahead of any pending retire.
- R7: A read completes with `cpu_rdy_o` high in the cycle `mem_ack_i` is high for it. In that cycle `cpu_rdata_o` carries `mem_rdata_i`, which holds the latest line the processor wrote to that address.
- R8: Once raised, `mem_req_o` stays high with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged until `mem_ack_i`. The count of pending lines never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until `cpu_rdy_o` |
| cpu_we_i | input | 1 | 1 = line write, 0 = line read |
| cpu_addr_i | input | ADDR_W | Processor byte address |
| cpu_wdata_i | input | LINE_W | Write line data |
| cpu_rdy_o | output | 1 | Request accepted (write) or completed (read) |
| cpu_rdata_o | output | LINE_W | Read line data, valid with `cpu_rdy_o` on a read |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = retire write, 0 = read |
| mem_addr_o | output | ADDR_W | Line-aligned memory address |
| mem_wdata_o | output | LINE_W | Retiring line data |
| mem_ack_i | input | 1 | Memory completes the current transaction |
| mem_rdata_i | input | LINE_W | Memory read line |

## Verification
The bench fills every slot under slow memory and checks that the next write waits exactly until the cycle after a retire; an off-by-one full flag would accept early and lose a line. It reads lines that are still queued, including at a nonzero byte offset and after two writes to the same line. A design that stalled only on the first matching slot, or compared offset bits, would return stale data. It reads a fresh line behind a full queue, so a design that retired writes before a missing read would show no bypass. A long mixed sequence against a small set of lines, with varying memory latency, compares retire order and data on every acknowledge.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE,
    PORT_RD,
    PORT_WR
  } port_op_e;
endpackage

// File: rtl/wbuf_tags.sv
module wbuf_tags #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 27,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             pop_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic [TAG_W-1:0] head_tag_o
);
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] match;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else begin
        if (pop_i && rd_ptr_q == PTR_W'(i)) valid_q[i] <= 1'b0;
        if (push_i && wr_ptr_q == PTR_W'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= push_tag_i;
        end
      end
    end
    assign match[i] = valid_q[i] && (tag_q[i] == look_tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign hit_o      = |match;
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign count_o    = cnt_q;
  assign wr_idx_o   = wr_ptr_q;
  assign rd_idx_o   = rd_ptr_q;
  assign head_tag_o = tag_q[rd_ptr_q];
endmodule

// File: rtl/wbuf_data.sv
module wbuf_data #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 256,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [LINE_W-1:0] rd_line_o
);
  logic [LINE_W-1:0] line_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(i)) line_q[i] <= wr_line_i;
    end
  end

  assign rd_line_o = line_q[rd_idx_i];
endmodule

// File: rtl/wbuf_port_ctl.sv
module wbuf_port_ctl
  import wbuf_pkg::*;
#(
  parameter int TAG_W  = 27,
  parameter int LINE_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic              hit_i,
  input  logic              empty_i,
  input  logic [TAG_W-1:0]  head_tag_i,
  input  logic [LINE_W-1:0] head_line_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [TAG_W-1:0]  mem_tag_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  output logic              pop_o,
  output logic              rd_done_o
);
  port_op_e          op_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= PORT_IDLE;
      tag_q  <= '0;
      line_q <= '0;
    end else begin
      unique case (op_q)
        PORT_IDLE: begin
          // read miss wins the idle port over retires
          if (rd_req_i && !hit_i) begin
            op_q  <= PORT_RD;
            tag_q <= rd_tag_i;
          end else if (!empty_i) begin
            op_q   <= PORT_WR;
            tag_q  <= head_tag_i;
            line_q <= head_line_i;
          end
        end
        default: if (mem_ack_i) op_q <= PORT_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (op_q != PORT_IDLE);
  assign mem_we_o    = (op_q == PORT_WR);
  assign mem_tag_o   = tag_q;
  assign mem_wdata_o = line_q;
  assign pop_o       = (op_q == PORT_WR) && mem_ack_i;
  assign rd_done_o   = (op_q == PORT_RD) && mem_ack_i;
endmodule

// File: rtl/wbuf_snoop.sv
module wbuf_snoop #(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 64,
  parameter int QW_NUM = 4,
  parameter int DEPTH  = 4,
  localparam int LINE_W = QW_W * QW_NUM,
  localparam int OFS_W  = $clog2(LINE_W / 8),
  localparam int TAG_W  = ADDR_W - OFS_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [LINE_W-1:0] cpu_wdata_i,
  output logic              cpu_rdy_o,
  output logic [LINE_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  logic [TAG_W-1:0]  cpu_tag, head_tag, mem_tag;
  logic              wr_acc, pop, rd_done;
  logic              snoop_hit, buf_full, buf_empty;
  logic [CNT_W-1:0]  buf_count;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [LINE_W-1:0] head_line;
  logic              unused_ofs;

  assign cpu_tag    = cpu_addr_i[ADDR_W-1:OFS_W];
  assign unused_ofs = ^cpu_addr_i[OFS_W-1:0];
  assign wr_acc     = cpu_req_i && cpu_we_i && !buf_full;

  wbuf_tags #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_acc),
    .push_tag_i (cpu_tag),
    .pop_i      (pop),
    .look_tag_i (cpu_tag),
    .hit_o      (snoop_hit),
    .full_o     (buf_full),
    .empty_o    (buf_empty),
    .count_o    (buf_count),
    .wr_idx_o   (wr_idx),
    .rd_idx_o   (rd_idx),
    .head_tag_o (head_tag)
  );

  wbuf_data #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_acc),
    .wr_idx_i  (wr_idx),
    .wr_line_i (cpu_wdata_i),
    .rd_idx_i  (rd_idx),
    .rd_line_o (head_line)
  );

  wbuf_port_ctl #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (cpu_req_i && !cpu_we_i),
    .rd_tag_i    (cpu_tag),
    .hit_i       (snoop_hit),
    .empty_i     (buf_empty),
    .head_tag_i  (head_tag),
    .head_line_i (head_line),
    .mem_ack_i   (mem_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_tag_o   (mem_tag),
    .mem_wdata_o (mem_wdata_o),
    .pop_o       (pop),
    .rd_done_o   (rd_done)
  );

  assign mem_addr_o  = {mem_tag, {OFS_W{1'b0}}};
  assign cpu_rdy_o   = wr_acc || rd_done;
  assign cpu_rdata_o = mem_rdata_i;
endmodule

// File: rtl/wbuf_snoop_chk.sv
module wbuf_snoop_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_rdy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LINE_W-1:0] mem_wdata_o,
  input logic              hit,
  input logic              full,
  input logic [CNT_W-1:0]  count
);
  // R5
  read_hit_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_we_i && hit |-> !cpu_rdy_o);

  // R3
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && full |-> !cpu_rdy_o);

  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  // R6
  read_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && cpu_req_i && !cpu_we_i && !hit |=> mem_req_o && !mem_we_o);

  // R7
  read_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |-> cpu_rdy_o);
endmodule

bind wbuf_snoop wbuf_snoop_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_rdy_o   (cpu_rdy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .hit         (snoop_hit),
  .full        (buf_full),
  .count       (buf_count)
);

// File: tb/wbuf_snoop_tb.sv
module wbuf_snoop_tb;
  localparam int AW = 32;
  localparam int LW = 256;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [LW-1:0] cpu_wdata = '0;
  logic cpu_rdy;
  logic [LW-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [LW-1:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wbuf_snoop #(.ADDR_W(AW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdy_o(cpu_rdy), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  typedef struct {
    int unsigned   tag;
    logic [LW-1:0] data;
  } ent_t;

  ent_t          q[$];
  logic [LW-1:0] shadow [int unsigned];
  logic [LW-1:0] store  [int unsigned];
  bit            wr_ack_now = 0;
  int unsigned   ack_tag = 0;
  int            lat = 0, cnt = 0, bypass_cnt = 0;
  int            n_chk = 0, n_err = 0;
  bit            prev_wait = 0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [LW-1:0] init_line(input int unsigned t);
    return {8{t ^ 32'hA5C3_0F1E}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and retire-order model
  always @(negedge clk) begin
    if (!rst_ni) begin
      mem_ack = 0; cnt = 0; wr_ack_now = 0; prev_wait = 0;
    end else if (mem_ack) begin
      mem_ack = 0; wr_ack_now = 0; cnt = 0; prev_wait = 0;
    end else if (mem_req) begin
      if (prev_wait) chk(mem_addr == prev_addr, "R8", LW'(mem_addr), LW'(prev_addr));
      if (cnt >= lat) begin
        int unsigned t;
        t = mem_addr[AW-1:5];
        if (mem_we) begin
          chk(q.size() > 0, "R4", LW'(q.size()), LW'(1));
          if (q.size() > 0) begin
            chk(mem_addr == {q[0].tag[AW-6:0], 5'b0}, "R4", LW'(mem_addr),
                LW'({q[0].tag[AW-6:0], 5'b0}));
            chk(mem_wdata == q[0].data, "R4", mem_wdata, q[0].data);
            void'(q.pop_front());
          end
          store[t] = mem_wdata;
          ack_tag = t;
          wr_ack_now = 1;
        end else begin
          bit pend;
          pend = 0;
          foreach (q[i]) if (q[i].tag == t) pend = 1;
          chk(!pend, "R5", LW'(pend), LW'(0));
          if (q.size() > 0) bypass_cnt++;
          mem_rdata = store.exists(t) ? store[t] : init_line(t);
        end
        mem_ack = 1;
      end else begin
        cnt++;
        prev_wait = 1;
        prev_addr = mem_addr;
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [LW-1:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    forever begin
      int occ;
      #3;
      occ = q.size() + int'(wr_ack_now);
      chk(cpu_rdy == (occ < DEPTH), (occ >= DEPTH) ? "R3" : "R2",
          LW'(cpu_rdy), LW'(occ < DEPTH));
      if (cpu_rdy) begin
        q.push_back('{tag: a[AW-1:5], data: d});
        shadow[a[AW-1:5]] = d;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int unsigned t;
    t = a[AW-1:5];
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    forever begin
      bit hit_m;
      #3;
      hit_m = wr_ack_now && (ack_tag == t);
      foreach (q[i]) if (q[i].tag == t) hit_m = 1;
      if (hit_m) chk(!cpu_rdy, "R5", LW'(cpu_rdy), LW'(0));
      if (cpu_rdy) begin
        logic [LW-1:0] e;
        e = shadow.exists(t) ? shadow[t] : init_line(t);
        chk(cpu_rdata == e, "R7", cpu_rdata, e);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic drain();
    while (q.size() > 0 || mem_req) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk); #3;
    // R1 reset state
    chk(mem_req == 0, "R1", LW'(mem_req), LW'(0));
    chk(cpu_rdy == 0, "R1", LW'(cpu_rdy), LW'(0));

    // R2/R3: fill with slow memory, fifth write waits for a retire
    lat = 6;
    for (int i = 0; i < 5; i++) do_write(32'h1000 + 32'(i) * 32, {8{32'h1111_0000 + 32'(i)}});

    // R6: read of a fresh line behind queued writes goes around them
    begin
      int b0;
      b0 = bypass_cnt;
      do_write(32'h2000, {8{32'hBEEF_0001}});
      do_read(32'h9000);
      chk(bypass_cnt > b0, "R6", LW'(bypass_cnt), LW'(b0 + 1));
      chk(q.size() > 0, "R6", LW'(q.size()), LW'(1));
    end
    drain();

    // R5: read of queued line at nonzero offset, two writes to the same line
    lat = 3;
    do_write(32'h3000, {8{32'hAAAA_0001}});
    do_write(32'h3008, {8{32'hAAAA_0002}});
    do_write(32'h4000, {8{32'hCCCC_0003}});
    do_read(32'h3010);
    chk(q.size() <= 1, "R5", LW'(q.size()), LW'(1));
    drain();

    // R7: read with empty buffer, fast memory
    lat = 0;
    do_read(32'h3000);
    do_read(32'h5000);

    // mixed traffic over a few lines
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      lat = $urandom_range(0, 4);
      a = 32'h8000 + 32'($urandom_range(0, 5)) * 32 + 32'($urandom_range(0, 31));
      if ($urandom_range(0, 2) != 0) do_write(a, {$urandom, $urandom, $urandom, $urandom,
                                                   $urandom, $urandom, $urandom, $urandom});
      else do_read(a);
    end
    drain();
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule